// File: doc/BRIEF.md
# BCD Clock-Calendar Counter with Half-Minute Rounding

This block keeps wall-clock time and a calendar date in packed BCD. A single-cycle enable arriving at 4096 Hz (derived elsewhere from a 32.768 kHz oscillator) feeds a sub-second prescaler. The prescaler produces one seconds step per `TICKS_PER_SEC` enables. From that step the block advances seconds, minutes and 24-hour hours, then a 3-bit weekday, the date, the month and a four-digit year. Month lengths and leap years are handled automatically.

Software-style access goes through a single write port that selects one field at a time. A write can preset any time or date field. It can also set or clear a halt control, request a round-to-nearest-minute correction, or clear a sticky flag that records oscillator stoppage. A busy output warns that the counters are about to change. A one-cycle pulse marks every carry from seconds into minutes, so that neighbouring logic such as an alarm comparator can use it.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 and hours 00 to 23 in packed BCD. Each wraps to 00 and carries into the next field.
- R2: `wday` counts 0 to 6 (0 = Sunday), advances once per midnight, and wraps from 6 to 0.
- R3: Dates run 01 to the month length: 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. Months run 01 to 12. December 31 rolls over to January 01, and the year increments in BCD.
- R4: February has 29 days when the year is divisible by 4 and 28 days otherwise, over the years 1901 to 2099.
- R5: `wr_sel`=7 with `wr_data[1]`=1 requests a rounding correction, which executes on the next `tick_4k`. It sets seconds to 00 and clears the prescaler. If seconds were 30 to 59, minutes also increment (with a `min_carry` pulse); if seconds were 00 to 29, minutes are unchanged. The request then clears itself.
- R6: `busy` is 1 throughout the last `tick_4k` period before each seconds step, and while a rounding request is pending. It is 0 at other times.
- R7: `wr_sel`=7 with `wr_data[0]`=1 halts counting and holds the prescaler cleared. Writing 0 resumes counting, and the first seconds step comes after a full `TICKS_PER_SEC` enables.
- R8: `osc_fail` is 1 after reset and is set whenever `osc_stopped` is 1. `wr_sel`=8 with `wr_data[0]`=0 clears it; writing 1 has no effect.
- R9: With `wr_en`=1, `wr_sel` selects the field to preset: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year (16-bit BCD). The new value appears after the next clock edge. If a carry into that field would occur in the same cycle, the write wins and no carry passes onward.
- R10: `min_carry` is high for exactly one cycle, in the cycle after each seconds-to-minutes carry.
- R11: Reset (synchronous, active high) gives 00:00:00, weekday 0, date 2000-01-01, not halted, no pending request, `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k | input | 1 | One-cycle enable at the 4096 Hz rate |
| osc_stopped | input | 1 | Oscillator-stopped indication |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select for the write |
| wr_data | input | 16 | Write data (BCD for time fields) |
| sec_bcd | output | 8 | Seconds, BCD |
| min_bcd | output | 8 | Minutes, BCD |
| hour_bcd | output | 8 | Hours 00-23, BCD |
| wday | output | 3 | Weekday code 0-6 |
| date_bcd | output | 8 | Day of month, BCD |
| month_bcd | output | 8 | Month, BCD |
| year_bcd | output | 16 | Four-digit year, BCD |
| busy | output | 1 | Update-imminent indicator |
| osc_fail | output | 1 | Sticky oscillator-failure flag |
| min_carry | output | 1 | One-cycle pulse per seconds-to-minutes carry |

## Verification
The case hardest to reach from the ports is a field write that lands in exactly the same cycle as the carry it must override. The prescaler phase is not visible, but `busy` reveals it. The bench therefore steps enables until `busy` rises, and then drives the enable together with a seconds write while the seconds sit at 59. Calendar rollover is swept across two full years, one of them a leap year. Each day is forced to 23:59:59 and stepped one second, so every month end, both kinds of February, and the weekday wrap are all compared against an arithmetic model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [3:0] {
    SEL_SEC   = 4'd0,
    SEL_MIN   = 4'd1,
    SEL_HOUR  = 4'd2,
    SEL_WDAY  = 4'd3,
    SEL_DATE  = 4'd4,
    SEL_MONTH = 4'd5,
    SEL_YEAR  = 4'd6,
    SEL_CTRL  = 4'd7,
    SEL_OSCF  = 4'd8
  } field_sel_e;

  // Two-digit BCD increment without wrap; the caller handles the limit.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four, judged from the two low BCD digits of the year.
  function automatic logic leap_yy(input logic [7:0] yy);
    if (!yy[4]) return (yy[3:0] == 4'd0) || (yy[3:0] == 4'd4) || (yy[3:0] == 4'd8);
    else        return (yy[3:0] == 4'd2) || (yy[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic halt,
  input  logic clear,
  output logic last,
  output logic sec_tick
);
  localparam int DW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICKS_PER_SEC - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || halt)      div_q <= '0;
    else if (tick) begin
      if (clear || div_q == LAST) div_q <= '0;
      else                        div_q <= div_q + 1'b1;
    end
  end

  assign last     = !halt && (div_q == LAST);
  assign sec_tick = tick && !halt && !clear && (div_q == LAST);
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] LO = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic [7:0] hi,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] val,
  output logic       wrap
);
  always_ff @(posedge clk) begin
    if (rst)      val <= LO;
    else if (wr)  val <= wdata;
    else if (inc) val <= (val >= hi) ? LO : bcd_inc8(val);
  end

  assign wrap = inc && !wr && (val >= hi);
endmodule

// File: rtl/rtc_bcd_year.sv
module rtc_bcd_year #(
  parameter int                  DIGITS  = 4,
  parameter logic [4*DIGITS-1:0] RST_VAL = 16'h2000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inc,
  input  logic                  wr,
  input  logic [4*DIGITS-1:0]   wdata,
  output logic [4*DIGITS-1:0]   val
);
  logic [3:0]    dig_q [DIGITS];
  logic [DIGITS:0] cy;

  assign cy[0] = inc;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign cy[i+1]     = cy[i] && (dig_q[i] == 4'd9);
    assign val[4*i +: 4] = dig_q[i];

    always_ff @(posedge clk) begin
      if (rst)        dig_q[i] <= RST_VAL[4*i +: 4];
      else if (wr)    dig_q[i] <= wdata[4*i +: 4];
      else if (cy[i]) dig_q[i] <= (dig_q[i] == 4'd9) ? 4'd0 : dig_q[i] + 4'd1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_4k,
  input  logic        osc_stopped,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [15:0] wr_data,
  output logic [7:0]  sec_bcd,
  output logic [7:0]  min_bcd,
  output logic [7:0]  hour_bcd,
  output logic [2:0]  wday,
  output logic [7:0]  date_bcd,
  output logic [7:0]  month_bcd,
  output logic [15:0] year_bcd,
  output logic        busy,
  output logic        osc_fail,
  output logic        min_carry
);
  logic stop_q, adj_q, adj_fire, div_last, sec_tick;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;
  logic min_inc, wr_s, wr_m, wr_h, wr_d, wr_mo, wr_y;

  assign wr_s  = wr_en && (wr_sel == SEL_SEC);
  assign wr_m  = wr_en && (wr_sel == SEL_MIN);
  assign wr_h  = wr_en && (wr_sel == SEL_HOUR);
  assign wr_d  = wr_en && (wr_sel == SEL_DATE);
  assign wr_mo = wr_en && (wr_sel == SEL_MONTH);
  assign wr_y  = wr_en && (wr_sel == SEL_YEAR);

  assign adj_fire = adj_q && tick_4k;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_4k), .halt(stop_q), .clear(adj_fire),
    .last(div_last), .sec_tick(sec_tick)
  );

  rtc_bcd_field #(.LO(8'h00)) u_sec (
    .clk(clk), .rst(rst), .inc(sec_tick), .hi(8'h59),
    .wr(wr_s || adj_fire), .wdata(wr_s ? wr_data[7:0] : 8'h00),
    .val(sec_bcd), .wrap(sec_wrap)
  );

  // Rounding carries into minutes when the old seconds were in the upper half.
  assign min_inc = sec_wrap || (adj_fire && !wr_s && (sec_bcd >= 8'h30));

  rtc_bcd_field #(.LO(8'h00)) u_min (
    .clk(clk), .rst(rst), .inc(min_inc), .hi(8'h59),
    .wr(wr_m), .wdata(wr_data[7:0]), .val(min_bcd), .wrap(min_wrap)
  );

  rtc_bcd_field #(.LO(8'h00)) u_hour (
    .clk(clk), .rst(rst), .inc(min_wrap), .hi(8'h23),
    .wr(wr_h), .wdata(wr_data[7:0]), .val(hour_bcd), .wrap(hour_wrap)
  );

  rtc_bcd_field #(.LO(8'h01)) u_date (
    .clk(clk), .rst(rst), .inc(hour_wrap),
    .hi(last_day(month_bcd, leap_yy(year_bcd[7:0]))),
    .wr(wr_d), .wdata(wr_data[7:0]), .val(date_bcd), .wrap(date_wrap)
  );

  rtc_bcd_field #(.LO(8'h01)) u_month (
    .clk(clk), .rst(rst), .inc(date_wrap), .hi(8'h12),
    .wr(wr_mo), .wdata(wr_data[7:0]), .val(month_bcd), .wrap(month_wrap)
  );

  rtc_bcd_year #(.DIGITS(4), .RST_VAL(16'h2000)) u_year (
    .clk(clk), .rst(rst), .inc(month_wrap), .wr(wr_y), .wdata(wr_data), .val(year_bcd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wday      <= 3'd0;
      stop_q    <= 1'b0;
      adj_q     <= 1'b0;
      osc_fail  <= 1'b1;
      min_carry <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_WDAY) wday <= wr_data[2:0];
      else if (hour_wrap)              wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;

      if (wr_en && wr_sel == SEL_CTRL) stop_q <= wr_data[0];

      if (wr_en && wr_sel == SEL_CTRL && wr_data[1]) adj_q <= 1'b1;
      else if (adj_fire)                             adj_q <= 1'b0;

      if (osc_stopped)                                      osc_fail <= 1'b1;
      else if (wr_en && wr_sel == SEL_OSCF && !wr_data[0])  osc_fail <= 1'b0;

      min_carry <= min_inc;
    end
  end

  assign busy = div_last || adj_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_4k,
  input logic       wr_en,
  input logic       osc_stopped,
  input logic [7:0] sec_bcd,
  input logic [7:0] hour_bcd,
  input logic [2:0] wday,
  input logic [7:0] date_bcd,
  input logic [7:0] month_bcd,
  input logic       busy,
  input logic       osc_fail,
  input logic       min_carry,
  input logic       stop_q,
  input logic       adj_q
);
  p_sec_range_r1: assert property (@(posedge clk) disable iff (rst)
    sec_bcd <= 8'h59 && sec_bcd[3:0] <= 4'd9);

  p_hour_range_r1: assert property (@(posedge clk) disable iff (rst)
    hour_bcd <= 8'h23);

  p_wday_range_r2: assert property (@(posedge clk) disable iff (rst)
    wday <= 3'd6);

  p_date_range_r3: assert property (@(posedge clk) disable iff (rst)
    date_bcd >= 8'h01 && date_bcd <= 8'h31 && month_bcd >= 8'h01 && month_bcd <= 8'h12);

  p_adj_self_clear_r5: assert property (@(posedge clk) disable iff (rst)
    adj_q && tick_4k && !wr_en |=> !adj_q);

  p_busy_before_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sec_bcd) && !$past(wr_en) |-> $past(busy));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    stop_q && !adj_q && !wr_en |=> $stable(sec_bcd));

  p_oscfail_set_r8: assert property (@(posedge clk) disable iff (rst)
    osc_stopped |=> osc_fail);

  p_oscfail_hold_r8: assert property (@(posedge clk) disable iff (rst)
    osc_fail && !wr_en |=> osc_fail);

  p_carry_zero_sec_r10: assert property (@(posedge clk) disable iff (rst)
    min_carry |-> sec_bcd == 8'h00);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .tick_4k(tick_4k), .wr_en(wr_en), .osc_stopped(osc_stopped),
  .sec_bcd(sec_bcd), .hour_bcd(hour_bcd), .wday(wday), .date_bcd(date_bcd),
  .month_bcd(month_bcd), .busy(busy), .osc_fail(osc_fail), .min_carry(min_carry),
  .stop_q(stop_q), .adj_q(adj_q)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
  localparam int TPS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_4k = 1'b0, osc_stopped = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  sec_bcd, min_bcd, hour_bcd, date_bcd, month_bcd;
  logic [2:0]  wday;
  logic [15:0] year_bcd;
  logic        busy, osc_fail, min_carry;

  int n_cmp = 0, n_bad = 0, carry_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst(rst), .tick_4k(tick_4k), .osc_stopped(osc_stopped),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .wday(wday),
    .date_bcd(date_bcd), .month_bcd(month_bcd), .year_bcd(year_bcd),
    .busy(busy), .osc_fail(osc_fail), .min_carry(min_carry)
  );

  function automatic logic [7:0] bcd2(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic logic [15:0] bcd4(input int n);
    return {bcd2(n / 100), bcd2(n % 100)};
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_4k = 1'b1;
    @(negedge clk) tick_4k = 1'b0;
    if (min_carry) carry_cnt++;
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic step_sec();
    for (int k = 0; k < TPS; k++) do_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int y, m, d, wd, c0;
    logic [7:0] s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 sec", sec_bcd, 8'h00);
    check("R11 min", min_bcd, 8'h00);
    check("R11 hour", hour_bcd, 8'h00);
    check("R11 wday", wday, 3'd0);
    check("R11 date", {year_bcd, month_bcd, date_bcd}, 32'h2000_0101);
    check("R11 busy", busy, 1'b0);
    check("R8 osc_fail after reset", osc_fail, 1'b1);

    // R1 sweep over 3661 seconds, plus R10 carry pulse count
    for (int s = 1; s <= 3661; s++) begin
      step_sec();
      check("R1 sec", sec_bcd, bcd2(s % 60));
      check("R1 min", min_bcd, bcd2((s / 60) % 60));
      check("R1 hour", hour_bcd, bcd2(s / 3600));
    end
    check("R10 carry pulses", carry_cnt, 61);

    // R9 write vs carry in the same cycle
    wr(4'd1, 16'h0005);
    wr(4'd0, 16'h0059);
    while (!busy) do_tick();
    @(negedge clk) begin tick_4k = 1'b1; wr_en = 1'b1; wr_sel = 4'd0; wr_data = 16'h0010; end
    @(negedge clk) begin tick_4k = 1'b0; wr_en = 1'b0; end
    check("R9 write beats carry sec", sec_bcd, 8'h10);
    check("R9 no carry to min", min_bcd, 8'h05);
    check("R10 no pulse when write wins", min_carry, 1'b0);

    // R5 rounding at 29 seconds
    wr(4'd2, 16'h0010);
    wr(4'd1, 16'h0015);
    wr(4'd0, 16'h0029);
    wr(4'd7, 16'h0002);
    check("R6 busy while request pending", busy, 1'b1);
    check("R5 no change before tick", sec_bcd, 8'h29);
    do_tick();
    check("R5 adj29 sec", sec_bcd, 8'h00);
    check("R5 adj29 min", min_bcd, 8'h15);
    check("R5 adj29 no pulse", min_carry, 1'b0);
    check("R5 request cleared", busy, 1'b0);
    // R5 rounding at 30 seconds
    wr(4'd0, 16'h0030);
    wr(4'd7, 16'h0002);
    do_tick();
    check("R5 adj30 sec", sec_bcd, 8'h00);
    check("R5 adj30 min", min_bcd, 8'h16);
    check("R10 adj30 pulse", min_carry, 1'b1);
    @(negedge clk);
    check("R10 pulse one cycle", min_carry, 1'b0);
    // R5 prescaler cleared by the rounding; R6 busy window
    for (int k = 0; k < TPS - 2; k++) do_tick();
    check("R6 busy low mid-second", busy, 1'b0);
    do_tick();
    check("R6 busy in last period", busy, 1'b1);
    check("R5 divider reset sec", sec_bcd, 8'h00);
    do_tick();
    check("R5 step after full second", sec_bcd, 8'h01);
    check("R6 busy drops after step", busy, 1'b0);

    // R7 halt
    wr(4'd7, 16'h0001);
    s0 = sec_bcd;
    for (int k = 0; k < 3 * TPS; k++) do_tick();
    check("R7 frozen", sec_bcd, s0);
    check("R7 busy low while halted", busy, 1'b0);
    wr(4'd7, 16'h0000);
    for (int k = 0; k < TPS - 1; k++) do_tick();
    check("R7 resume waits full second", sec_bcd, s0);
    do_tick();
    check("R7 resume step", sec_bcd, bcd2(2));

    // R8 oscillator-fail flag
    wr(4'd8, 16'h0000);
    check("R8 clear by 0", osc_fail, 1'b0);
    wr(4'd8, 16'h0001);
    check("R8 write 1 ignored", osc_fail, 1'b0);
    @(negedge clk) osc_stopped = 1'b1;
    @(negedge clk) osc_stopped = 1'b0;
    check("R8 set by stop input", osc_fail, 1'b1);

    // R3 millennium rollover
    wr(4'd6, 16'h1999); wr(4'd5, 16'h0012); wr(4'd4, 16'h0031); wr(4'd3, 16'h0005);
    wr(4'd2, 16'h0023); wr(4'd1, 16'h0059); wr(4'd0, 16'h0059);
    c0 = carry_cnt;
    step_sec();
    check("R3 new year date", {year_bcd, month_bcd, date_bcd}, 32'h2000_0101);
    check("R1 midnight time", {8'h00, hour_bcd, min_bcd, sec_bcd}, 32'h0);
    check("R2 weekday advance", wday, 3'd6);
    check("R10 midnight pulse", carry_cnt - c0, 1);

    // R2 R3 R4 two-year daily sweep 2023..2024
    y = 2023; m = 1; d = 1; wd = 0;
    wr(4'd6, bcd4(y)); wr(4'd5, 16'h0001); wr(4'd4, 16'h0001); wr(4'd3, 16'h0000);
    for (int n = 0; n < 731; n++) begin
      int pm;
      pm = m;
      wr(4'd2, 16'h0023); wr(4'd1, 16'h0059); wr(4'd0, 16'h0059);
      step_sec();
      wd = (wd + 1) % 7;
      d++;
      if (d > mdays(m, y)) begin
        d = 1; m++;
        if (m > 12) begin m = 1; y++; end
      end
      if (pm == 2) check("R4 feb end", {month_bcd, date_bcd}, {16'h0, bcd2(m), bcd2(d)});
      else         check("R3 date", {month_bcd, date_bcd}, {16'h0, bcd2(m), bcd2(d)});
      check("R3 year", year_bcd, bcd4(y));
      check("R2 wday", wday, wd);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule